// File: doc/BRIEF.md
# Configurable Add and Compare Unit

This block is a one-cycle execution unit built around a single adder. Each operand can be bit-inverted on its own before the addition, and a carry-in bit is added to the sum. Choosing the inversions and the carry-in turns that one adder into a plain adder, a subtractor, a less-than test, a greater-or-equal test, or an equality test. A sign bit turns the ordered comparisons into signed ones. All comparison outcomes come from the carry behaviour of that one adder, so the block needs no separate comparator.

A result-mode input chooses what is returned. In sum mode the 32-bit sum is returned. In flag mode the one-bit comparison outcome is returned, zero-extended. When the branch-check enable is set, the outcome is compared with a predicted-taken input, and a mispredict flag is raised when the two differ. An issuing pipeline drives one operation per cycle with `in_valid`. The result appears on the registered outputs on the next clock edge.

Top module: `addcmp_unit`

## Requirements
- R1: With no inversion, carry-in 0 and sum mode, `result` is `op_a + op_b` modulo 2^32.
- R2: With `inv_b`=1, `carry_in`=1 and sum mode, `result` is `op_a - op_b` modulo 2^32.
- R3: With `inv_a`=1, `inv_b`=0, `carry_in`=0, `signed_cmp`=0, `eq_mode`=0 and flag mode, `result[0]` is 1 exactly when `op_a < op_b` as unsigned numbers.
- R4: The R3 setting with `signed_cmp`=1 gives 1 exactly when `op_a < op_b` as two's-complement numbers.
- R5: With `inv_b`=1, `carry_in`=1, `eq_mode`=0 and flag mode, `result[0]` is 1 exactly when `op_a >= op_b`. The test is unsigned when `signed_cmp`=0 and signed when `signed_cmp`=1.
- R6: With `eq_mode`=1, the outcome is 1 when (A' XOR B') is all ones and `carry_in`=1. It is the complement of that test when `carry_in`=0. So `inv_a`=1 with `carry_in`=1 tests a==b, and `inv_b`=1 with `carry_in`=0 tests a!=b.
- R7: In flag mode (`hi_mode`=1), bits 31..1 of `result` are 0.
- R8: `mispredict` is (outcome XOR `pred_taken`) when `check_en`=1. It is 0 when `check_en`=0, whatever the value of `pred_taken`.
- R9: `out_valid` follows `in_valid` one cycle later, and `result` and `mispredict` belong to the operation issued one cycle earlier. After reset, `out_valid`, `result` and `mispredict` are 0. `mispredict` is 0 in any cycle in which `out_valid` is 0.
- R10: In sum mode, `signed_cmp` and `eq_mode` have no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is issued this cycle |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| inv_a | input | 1 | Bit-invert A before the addition |
| inv_b | input | 1 | Bit-invert B before the addition |
| carry_in | input | 1 | Carry added into bit 0 |
| signed_cmp | input | 1 | Use a signed comparison |
| eq_mode | input | 1 | Use the equality test instead of the carry |
| check_en | input | 1 | Compare the outcome with the prediction |
| hi_mode | input | 1 | 1: return the flag; 0: return the sum |
| pred_taken | input | 1 | Predicted outcome |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Sum, or the zero-extended flag |
| mispredict | output | 1 | Outcome differs from the prediction |

## Verification
The bench targets the operand pairs where a carry-based compare goes wrong:
- Equal operands. A design with the wrong carry-in would report less-than for them.
- 0x7FFFFFFF against 0x80000000, and -1 against 1. A design that does not flip the sign bit would give the reversed answer.
- Wrap-around in sum mode, together with sum-mode operations that have the sign bit set. A design that leaked the sign flip into the sum would return a wrong value here.
- Predictions that disagree with the outcome, with the check enabled and with it disabled. These expose a mispredict flag that is inverted or that is not gated by the enable.

// File: rtl/addcmp_pkg.sv
package addcmp_pkg;
  typedef struct packed {
    logic inv_a;
    logic inv_b;
    logic cin;
    logic sgn;
    logic eq;
    logic chk;
  } addcmp_ctl_t;

  typedef enum logic {
    RES_SUM  = 1'b0,
    RES_FLAG = 1'b1
  } addcmp_res_e;
endpackage

// File: rtl/addcmp_operand_prep.sv
module addcmp_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic         sgn,
  output logic [W-1:0] a_p,
  output logic [W-1:0] b_p,
  output logic [W-1:0] a_f,
  output logic [W-1:0] b_f
);
  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] cond_inv(input logic [W-1:0] v, input logic en);
    return en ? ~v : v;
  endfunction

  // Flipping the top bit maps two's complement onto offset binary.
  function automatic logic [W-1:0] sign_flip(input logic [W-1:0] v, input logic en);
    return en ? (v ^ MSB_MASK) : v;
  endfunction

  always_comb begin
    a_p = cond_inv(a, inv_a);
    b_p = cond_inv(b, inv_b);
    a_f = sign_flip(a_p, sgn);
    b_f = sign_flip(b_p, sgn);
  end
endmodule

// File: rtl/addcmp_adder.sv
module addcmp_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  function automatic logic [W:0] wide_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  logic [W:0] total;

  always_comb begin
    total = wide_add(a, b, cin);
    sum   = total[W-1:0];
    cout  = total[W];
  end
endmodule

// File: rtl/addcmp_resolve.sv
module addcmp_resolve #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_p,
  input  logic [W-1:0] b_p,
  input  logic [W-1:0] sum,
  input  logic         cout,
  input  logic         cin,
  input  logic         eq,
  input  logic         chk,
  input  logic         pred,
  input  logic         hi,
  output logic         outcome,
  output logic [W-1:0] res_next,
  output logic         mis_next
);
  function automatic logic eq_test(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic c);
    logic all_ones;
    all_ones = &(x ^ y);
    return c ? all_ones : ~all_ones;
  endfunction

  always_comb begin
    outcome  = eq ? eq_test(a_p, b_p, cin) : cout;
    res_next = hi ? {{(W-1){1'b0}}, outcome} : sum;
    mis_next = chk & (outcome ^ pred);
  end
endmodule

// File: rtl/addcmp_unit.sv
module addcmp_unit
  import addcmp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic         carry_in,
  input  logic         signed_cmp,
  input  logic         eq_mode,
  input  logic         check_en,
  input  logic         hi_mode,
  input  logic         pred_taken,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         mispredict
);
  addcmp_ctl_t ctl;
  addcmp_res_e rmode;
  logic [W-1:0] a_p, b_p, a_f, b_f, sum_w, res_next;
  logic         cout_w, outcome_w, mis_next;

  assign ctl   = '{inv_a: inv_a, inv_b: inv_b, cin: carry_in,
                   sgn: signed_cmp, eq: eq_mode, chk: check_en};
  assign rmode = hi_mode ? RES_FLAG : RES_SUM;

  addcmp_operand_prep #(.W(W)) u_prep (
    .a(op_a), .b(op_b), .inv_a(ctl.inv_a), .inv_b(ctl.inv_b), .sgn(ctl.sgn),
    .a_p(a_p), .b_p(b_p), .a_f(a_f), .b_f(b_f)
  );

  addcmp_adder #(.W(W)) u_add (
    .a(a_f), .b(b_f), .cin(ctl.cin), .sum(sum_w), .cout(cout_w)
  );

  addcmp_resolve #(.W(W)) u_res (
    .a_p(a_p), .b_p(b_p), .sum(sum_w), .cout(cout_w), .cin(ctl.cin),
    .eq(ctl.eq), .chk(ctl.chk), .pred(pred_taken), .hi(rmode == RES_FLAG),
    .outcome(outcome_w), .res_next(res_next), .mis_next(mis_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      mispredict <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= res_next;
        mispredict <= mis_next;
      end else begin
        mispredict <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/addcmp_unit_chk.sv
module addcmp_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         inv_a,
  input logic         inv_b,
  input logic         carry_in,
  input logic         signed_cmp,
  input logic         eq_mode,
  input logic         check_en,
  input logic         hi_mode,
  input logic         pred_taken,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         mispredict,
  input logic         outcome
);
  logic plain_ctl, lt_ctl, ge_ctl;
  assign plain_ctl = !inv_a && !inv_b && !carry_in;
  assign lt_ctl    = inv_a && !inv_b && !carry_in && !eq_mode;
  assign ge_ctl    = !inv_a && inv_b && carry_in && !eq_mode;

  assert_add_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !hi_mode && plain_ctl |=> result == $past(op_a) + $past(op_b));

  assert_sub_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !hi_mode && ge_ctl |=> result == $past(op_a) - $past(op_b));

  assert_ltu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hi_mode && lt_ctl && !signed_cmp |=> result[0] == ($past(op_a) < $past(op_b)));

  assert_lts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hi_mode && lt_ctl && signed_cmp
    |=> result[0] == ($signed($past(op_a)) < $signed($past(op_b))));

  assert_geu_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hi_mode && ge_ctl && !signed_cmp |=> result[0] == ($past(op_a) >= $past(op_b)));

  assert_eq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hi_mode && eq_mode && inv_a && !inv_b && carry_in
    |=> result[0] == ($past(op_a) == $past(op_b)));

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hi_mode |=> result[W-1:1] == '0);

  assert_mis_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && check_en |=> mispredict == ($past(outcome) ^ $past(pred_taken)));

  assert_mis_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !check_en |=> !mispredict);

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !mispredict);

  assert_sum_sign_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !hi_mode
    |=> result == ($past(inv_a) ? ~$past(op_a) : $past(op_a))
                + ($past(inv_b) ? ~$past(op_b) : $past(op_b)) + {{(W-1){1'b0}}, $past(carry_in)});
endmodule

bind addcmp_unit addcmp_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .inv_a(inv_a), .inv_b(inv_b), .carry_in(carry_in), .signed_cmp(signed_cmp),
  .eq_mode(eq_mode), .check_en(check_en), .hi_mode(hi_mode), .pred_taken(pred_taken),
  .out_valid(out_valid), .result(result), .mispredict(mispredict), .outcome(outcome_w)
);

// File: tb/addcmp_unit_test.sv
module addcmp_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        inv_a = 0, inv_b = 0, carry_in = 0, signed_cmp = 0;
  logic        eq_mode = 0, check_en = 0, hi_mode = 0, pred_taken = 0;
  logic        out_valid, mispredict;
  logic [31:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] res;
    logic        mis;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  addcmp_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .inv_a(inv_a), .inv_b(inv_b), .carry_in(carry_in), .signed_cmp(signed_cmp),
    .eq_mode(eq_mode), .check_en(check_en), .hi_mode(hi_mode), .pred_taken(pred_taken),
    .out_valid(out_valid), .result(result), .mispredict(mispredict)
  );

  // Reference outcome restated from value comparisons, not from a carry.
  function automatic logic ref_outcome(input logic [31:0] ap, input logic [31:0] bp,
                                       input logic ci, input logic sg, input logic eq);
    longint sa, sb_v;
    if (eq) return ci ? (ap == ~bp) : (ap != ~bp);
    if (sg) begin
      sa   = longint'($signed(ap));
      sb_v = longint'($signed(bp));
      return (sa + sb_v + longint'(ci)) >= 0;
    end
    return ci ? (ap >= ~bp) : (ap > ~bp);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [32:0] act,
                       input logic [32:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic ia,
                       input logic ib, input logic ci, input logic sg, input logic eq,
                       input logic ck, input logic hi, input logic pr, input string tag);
    exp_t e;
    logic [31:0] ap, bp;
    logic oc;
    ap = ia ? ~a : a;
    bp = ib ? ~b : b;
    oc = ref_outcome(ap, bp, ci, sg, eq);
    e.res = hi ? {31'd0, oc} : (ap + bp + {31'd0, ci});
    e.mis = ck & (oc ^ pr);
    e.tag = tag;
    @(negedge clk);
    sb.push_back(e);
    in_valid = 1; op_a = a; op_b = b; inv_a = ia; inv_b = ib; carry_in = ci;
    signed_cmp = sg; eq_mode = eq; check_en = ck; hi_mode = hi; pred_taken = pr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      pred_taken = 1; check_en = 1;
    end
  endtask

  // Monitor: pops one expected item per valid output.
  always @(posedge clk) begin
    #2;
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(0, "R9 unexpected out_valid", {1'b0, result}, 33'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result == e.res && mispredict == e.mis, e.tag,
              {mispredict, result}, {e.mis, e.res});
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 33'd0, 33'd1);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && result == 0 && mispredict == 0, "R9 reset state",
          {mispredict, result}, 33'd0);
    rst_n = 1;
    @(negedge clk);
    //            a             b          ia ib ci sg eq ck hi pr
    issue(32'd5,        32'd7,        0, 0, 0, 0, 0, 0, 0, 0, "R1 add");
    issue(32'hFFFFFFFF, 32'd1,        0, 0, 0, 0, 0, 0, 0, 0, "R1 add wrap");
    issue(32'd10,       32'd3,        0, 1, 1, 0, 0, 0, 0, 0, "R2 sub");
    issue(32'd3,        32'd10,       0, 1, 1, 0, 0, 0, 0, 0, "R2 sub negative");
    issue(32'd1,        32'd2,        1, 0, 0, 0, 0, 0, 1, 0, "R3 ltu true");
    issue(32'hFFFFFFFF, 32'd1,        1, 0, 0, 0, 0, 0, 1, 0, "R3 ltu large");
    issue(32'd5,        32'd5,        1, 0, 0, 0, 0, 0, 1, 0, "R3 ltu equal");
    issue(32'hFFFFFFFF, 32'd1,        1, 0, 0, 1, 0, 0, 1, 0, "R4 lt -1<1");
    issue(32'h7FFFFFFF, 32'h80000000, 1, 0, 0, 1, 0, 0, 1, 0, "R4 lt max/min");
    issue(32'h80000000, 32'h7FFFFFFF, 1, 0, 0, 1, 0, 0, 1, 0, "R4 lt min/max");
    issue(32'd5,        32'd5,        0, 1, 1, 0, 0, 0, 1, 0, "R5 geu equal");
    issue(32'd1,        32'hFFFFFFFF, 0, 1, 1, 0, 0, 0, 1, 0, "R5 geu false");
    issue(32'd0,        32'hFFFFFFFF, 0, 1, 1, 1, 0, 0, 1, 0, "R5 ge signed 0>=-1");
    issue(32'h1234ABCD, 32'h1234ABCD, 1, 0, 1, 0, 1, 0, 1, 0, "R6 eq match");
    issue(32'h1234ABCD, 32'h1234ABCC, 1, 0, 1, 0, 1, 0, 1, 0, "R6 eq differ");
    issue(32'h00000000, 32'h80000000, 0, 1, 0, 0, 1, 0, 1, 0, "R6 ne differ");
    issue(32'h55555555, 32'h55555555, 0, 1, 0, 1, 1, 0, 1, 0, "R6 ne equal signed");
    issue(32'hFFFFFFFF, 32'd1,        1, 0, 0, 1, 0, 1, 1, 0, "R8 mispredict taken");
    issue(32'hFFFFFFFF, 32'd1,        1, 0, 0, 1, 0, 1, 1, 1, "R8 predicted right");
    issue(32'd9,        32'd9,        1, 0, 1, 0, 1, 1, 1, 1, "R8 eq predicted right");
    issue(32'd2,        32'd1,        1, 0, 0, 0, 0, 0, 1, 1, "R8 check off");
    issue(32'hC0000000, 32'h80000000, 0, 0, 0, 1, 0, 0, 0, 0, "R10 sum signed set");
    issue(32'h00000003, 32'h00000004, 0, 0, 0, 0, 1, 0, 0, 0, "R10 sum eq set");
    issue(32'h80000000, 32'h80000001, 0, 0, 1, 0, 0, 0, 1, 0, "R7 flag upper zero");
    idle(3);
    check(out_valid == 0 && mispredict == 0, "R9 idle after burst",
          {mispredict, 31'd0, out_valid}, 33'd0);
    check(sb.size() == 0, "R9 all results delivered", 33'(sb.size()), 33'd0);
    done = 1;
    summary();
  end
endmodule